// File: doc/BRIEF.md
# Microsequenced Accumulator Processor Core

This core is a small multicycle processor built around a single accumulator. Each instruction runs as a sequence of microcycles. Some microcycles perform several register transfers at once. The register set is a program counter, a memory address register, a memory data register, an opcode register and the accumulator. The core has one single-port word memory interface: an address, write data, read data and a write enable. It also has a parallel input port, a strobed output port, one interrupt request line and a halted flag.

A word is 16 bits. The opcode sits in bits [15:12] and the operand address in bits [11:0]. The opcodes are:

| Opcode | Instruction |
|--------|-------------|
| 0 | add |
| 1 | and |
| 2 | clear |
| 3 | rotate left |
| 4 | load |
| 5 | store |
| 6 | jump-if-zero |
| 7 | input |
| 8 | output |
| 9 | halt |
| 10 | return-from-interrupt |
| 11 to 15 | no-operation |

The memory presents the word at `memAddr` during the cycle in which the address register holds it. The core captures that word into its data register at the end of the same cycle.

After every instruction the core checks a pending-interrupt flop. If an interrupt is pending and not masked, the core spends two cycles on it. It stores the address of the next instruction in word 0 and continues at word 1, with further interrupts masked. The return instruction reloads the program counter from word 0 and clears the mask.

Top module: `accum_cpu`

## Requirements
- R1: While reset is asserted and right after it is released, `halted`, `memWe` and `outStrobe` are low. The first instruction is fetched from address 0 with a cleared accumulator.
- R2: Fetch takes three cycles and a load takes six cycles in total. A program that starts with load then output raises `outStrobe` right after the 10th rising edge following reset release.
- R3: Add (0) adds the addressed word to the accumulator modulo 2^16. And (1) takes the bitwise AND with the addressed word. Load (4) copies the addressed word into the accumulator.
- R4: Clear (2) sets the accumulator to zero. Rotate (3) shifts the accumulator left by one bit, and bit 15 re-enters at bit 0.
- R5: Store (5) writes the accumulator to the addressed word with `memWe` high for exactly one cycle. No other word changes.
- R6: Jump-if-zero (6) loads the operand address into the program counter only when the accumulator is zero. Otherwise execution falls through to the next word.
- R7: Input (7) copies `inPort` into the accumulator. Output (8) copies the accumulator to `outPort` and raises `outStrobe` for one cycle. `outPort` changes only together with that strobe.
- R8: Halt (9) raises `halted`, and it stays high until reset. While halted the core writes no memory word and gives no strobe.
- R9: Opcodes 11 to 15 change neither the accumulator nor memory, and execution continues with the next word.
- R10: A pending interrupt is taken after the current instruction completes. The address of the next instruction is written to word 0, and execution continues at word 1.
- R11: While an interrupt routine runs, further requests stay pending but are not taken. Return (10) reloads the program counter from word 0 and unmasks, so a request still pending is taken right after the return.
- R12: A request pulse of one cycle on `irqReq` is latched and is taken even though the line has already fallen.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| memAddr | output | 12 | Word address to memory (address register) |
| memWdata | output | 16 | Write data to memory |
| memWe | output | 1 | Memory write enable |
| memRdata | input | 16 | Word read from `memAddr` |
| inPort | input | 16 | Parallel input sampled by the input instruction |
| outPort | output | 16 | Parallel output register |
| outStrobe | output | 1 | One-cycle pulse after `outPort` is updated |
| irqReq | input | 1 | Interrupt request, latched |
| halted | output | 1 | High once a halt has executed |

## Verification
The hardest case to reach from the ports is a second request that arrives while the interrupt routine is still running. That request must wait through the mask and must then re-enter the routine right after the return, so that word 0 is reused without being corrupted. The bench counts rising edges from reset release. It drives a one-cycle request during the main program's load, and a second request during the routine's first instruction. It then checks the exact order of output values and the saved return address. A broken mask would send the program into a loop, and a per-run cycle limit catches that loop.

// File: rtl/cpu_pkg.sv
package cpu_pkg;
  localparam int OPC_W = 4;

  localparam logic [OPC_W-1:0] OP_ADD = 4'd0;
  localparam logic [OPC_W-1:0] OP_AND = 4'd1;
  localparam logic [OPC_W-1:0] OP_CLR = 4'd2;
  localparam logic [OPC_W-1:0] OP_ROT = 4'd3;
  localparam logic [OPC_W-1:0] OP_LDA = 4'd4;
  localparam logic [OPC_W-1:0] OP_STA = 4'd5;
  localparam logic [OPC_W-1:0] OP_JZ  = 4'd6;
  localparam logic [OPC_W-1:0] OP_IN  = 4'd7;
  localparam logic [OPC_W-1:0] OP_OUT = 4'd8;
  localparam logic [OPC_W-1:0] OP_HLT = 4'd9;
  localparam logic [OPC_W-1:0] OP_RTI = 4'd10;

  typedef enum logic [3:0] {
    ST_F1, ST_F2, ST_F3, ST_DEC, ST_RD, ST_EXE, ST_WR, ST_INT1, ST_INT2, ST_HALT
  } stateT;

  typedef enum logic [2:0] {
    ACC_KEEP, ACC_ADD, ACC_AND, ACC_CLR, ACC_ROT, ACC_LOAD, ACC_IN
  } accOpT;

  typedef struct packed {
    logic  marFromPc;
    logic  marFromAddr;
    logic  marToSave;
    logic  mdrLoad;
    logic  pcInc;
    logic  pcFromMdr;
    logic  pcToVector;
    logic  opcLoad;
    accOpT accOp;
    logic  outLoad;
    logic  memWrite;
    logic  writePc;
  } ctrlT;
endpackage

// File: rtl/cpu_datapath.sv
module cpu_datapath
  import cpu_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int SAVE_ADDR = 0,
  parameter int VEC_ADDR  = 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  ctrlT                     ctrl,
  input  logic [DATA_W-1:0]        memRdata,
  input  logic [DATA_W-1:0]        inPort,
  output logic [DATA_W-OPC_W-1:0]  memAddr,
  output logic [DATA_W-1:0]        memWdata,
  output logic [DATA_W-1:0]        outPort,
  output logic                     outStrobe,
  output logic [OPC_W-1:0]         opc,
  output logic                     accZero
);
  localparam int ADDR_W = DATA_W - OPC_W;

  logic [ADDR_W-1:0] pcQ, marQ;
  logic [DATA_W-1:0] mdrQ, accQ, outQ;
  logic [OPC_W-1:0]  opcQ;
  logic              strobeQ;
  logic [ADDR_W-1:0] mdrAddr;

  assign mdrAddr = mdrQ[ADDR_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      pcQ     <= '0;
      marQ    <= '0;
      mdrQ    <= '0;
      accQ    <= '0;
      opcQ    <= '0;
      outQ    <= '0;
      strobeQ <= 1'b0;
    end else begin
      if (ctrl.marFromPc)        marQ <= pcQ;
      else if (ctrl.marFromAddr) marQ <= mdrAddr;
      else if (ctrl.marToSave)   marQ <= ADDR_W'(SAVE_ADDR);

      if (ctrl.mdrLoad) mdrQ <= memRdata;

      if (ctrl.pcToVector)     pcQ <= ADDR_W'(VEC_ADDR);
      else if (ctrl.pcFromMdr) pcQ <= mdrAddr;
      else if (ctrl.pcInc)     pcQ <= pcQ + 1'b1;

      if (ctrl.opcLoad) opcQ <= mdrQ[DATA_W-1 -: OPC_W];

      case (ctrl.accOp)
        ACC_ADD:  accQ <= accQ + mdrQ;
        ACC_AND:  accQ <= accQ & mdrQ;
        ACC_CLR:  accQ <= '0;
        ACC_ROT:  accQ <= {accQ[DATA_W-2:0], accQ[DATA_W-1]};
        ACC_LOAD: accQ <= mdrQ;
        ACC_IN:   accQ <= inPort;
        default:  accQ <= accQ;
      endcase

      if (ctrl.outLoad) outQ <= accQ;
      strobeQ <= ctrl.outLoad;
    end
  end

  assign memAddr   = marQ;
  assign memWdata  = ctrl.writePc ? DATA_W'(pcQ) : accQ;
  assign outPort   = outQ;
  assign outStrobe = strobeQ;
  assign opc       = opcQ;
  assign accZero   = (accQ == '0);
endmodule

// File: rtl/cpu_control.sv
module cpu_control
  import cpu_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [OPC_W-1:0] opc,
  input  logic             accZero,
  input  logic             irqReq,
  output ctrlT             ctrl,
  output logic             halted
);
  stateT stateQ, stateN;
  logic  pendingQ, maskQ;
  logic  instrDone, takeIrq, unmaskNow;

  always_comb begin
    ctrl      = '0;
    stateN    = stateQ;
    instrDone = 1'b0;
    takeIrq   = 1'b0;
    unmaskNow = 1'b0;
    case (stateQ)
      ST_F1: begin ctrl.marFromPc = 1'b1; stateN = ST_F2; end
      ST_F2: begin ctrl.mdrLoad = 1'b1; ctrl.pcInc = 1'b1; stateN = ST_F3; end
      ST_F3: begin ctrl.opcLoad = 1'b1; stateN = ST_DEC; end
      ST_DEC: begin
        case (opc)
          OP_ADD, OP_AND, OP_LDA: begin ctrl.marFromAddr = 1'b1; stateN = ST_RD; end
          OP_STA: begin ctrl.marFromAddr = 1'b1; stateN = ST_WR; end
          OP_RTI: begin ctrl.marToSave = 1'b1; stateN = ST_RD; end
          OP_CLR: begin ctrl.accOp = ACC_CLR; instrDone = 1'b1; end
          OP_ROT: begin ctrl.accOp = ACC_ROT; instrDone = 1'b1; end
          OP_IN:  begin ctrl.accOp = ACC_IN;  instrDone = 1'b1; end
          OP_OUT: begin ctrl.outLoad = 1'b1;  instrDone = 1'b1; end
          OP_JZ:  begin ctrl.pcFromMdr = accZero; instrDone = 1'b1; end
          OP_HLT: stateN = ST_HALT;
          default: instrDone = 1'b1;
        endcase
      end
      ST_RD: begin ctrl.mdrLoad = 1'b1; stateN = ST_EXE; end
      ST_EXE: begin
        case (opc)
          OP_ADD:  ctrl.accOp = ACC_ADD;
          OP_AND:  ctrl.accOp = ACC_AND;
          OP_RTI:  begin ctrl.pcFromMdr = 1'b1; unmaskNow = 1'b1; end
          default: ctrl.accOp = ACC_LOAD;
        endcase
        instrDone = 1'b1;
      end
      ST_WR: begin ctrl.memWrite = 1'b1; instrDone = 1'b1; end
      ST_INT1: begin ctrl.marToSave = 1'b1; stateN = ST_INT2; end
      ST_INT2: begin
        ctrl.memWrite   = 1'b1;
        ctrl.writePc    = 1'b1;
        ctrl.pcToVector = 1'b1;
        takeIrq         = 1'b1;
        stateN          = ST_F1;
      end
      default: stateN = ST_HALT;
    endcase
    if (instrDone)
      stateN = (pendingQ && (!maskQ || unmaskNow)) ? ST_INT1 : ST_F1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stateQ   <= ST_F1;
      pendingQ <= 1'b0;
      maskQ    <= 1'b0;
    end else begin
      stateQ   <= stateN;
      pendingQ <= takeIrq ? 1'b0 : (pendingQ | irqReq);
      if (takeIrq)        maskQ <= 1'b1;
      else if (unmaskNow) maskQ <= 1'b0;
    end
  end

  assign halted = (stateQ == ST_HALT);
endmodule

// File: rtl/accum_cpu.sv
module accum_cpu
  import cpu_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int SAVE_ADDR = 0,
  parameter int VEC_ADDR  = 1
) (
  input  logic                    clk,
  input  logic                    rst,
  output logic [DATA_W-OPC_W-1:0] memAddr,
  output logic [DATA_W-1:0]       memWdata,
  output logic                    memWe,
  input  logic [DATA_W-1:0]       memRdata,
  input  logic [DATA_W-1:0]       inPort,
  output logic [DATA_W-1:0]       outPort,
  output logic                    outStrobe,
  input  logic                    irqReq,
  output logic                    halted
);
  ctrlT             ctrl;
  logic [OPC_W-1:0] opc;
  logic             accZero;

  cpu_control u_ctrl (
    .clk(clk), .rst(rst), .opc(opc), .accZero(accZero),
    .irqReq(irqReq), .ctrl(ctrl), .halted(halted)
  );

  cpu_datapath #(.DATA_W(DATA_W), .SAVE_ADDR(SAVE_ADDR), .VEC_ADDR(VEC_ADDR)) u_dp (
    .clk(clk), .rst(rst), .ctrl(ctrl), .memRdata(memRdata), .inPort(inPort),
    .memAddr(memAddr), .memWdata(memWdata), .outPort(outPort),
    .outStrobe(outStrobe), .opc(opc), .accZero(accZero)
  );

  assign memWe = ctrl.memWrite;
endmodule

// File: rtl/cpu_checker.sv
module cpu_checker #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              memWe,
  input logic              outStrobe,
  input logic              halted,
  input logic [DATA_W-1:0] outPort
);
  // R5
  single_write_chk: assert property (@(posedge clk) disable iff (rst)
    memWe |=> !memWe);

  // R7
  out_change_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(outPort) |-> outStrobe);

  // R8
  halt_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    halted |=> halted);

  // R8
  halt_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    halted |-> (!memWe && !outStrobe));
endmodule

bind accum_cpu cpu_checker #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .memWe(memWe), .outStrobe(outStrobe),
  .halted(halted), .outPort(outPort)
);

// File: tb/accum_cpu_bench.sv
`timescale 1ns/1ps
module accum_cpu_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] memAddr;
  logic [15:0] memWdata, memRdata, inPort, outPort;
  logic        memWe, outStrobe, irqReq, halted;

  logic [15:0] mem [0:255];
  logic [15:0] outLog [0:15];
  int nOut, writeCount, edgeCnt, firstStrobeEdge;
  int checks = 0, fails = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  accum_cpu u_accum_cpu (
    .clk(clk), .rst(rst), .memAddr(memAddr), .memWdata(memWdata), .memWe(memWe),
    .memRdata(memRdata), .inPort(inPort), .outPort(outPort), .outStrobe(outStrobe),
    .irqReq(irqReq), .halted(halted)
  );

  assign memRdata = mem[memAddr[7:0]];

  always @(posedge clk) begin
    if (memWe) mem[memAddr[7:0]] <= memWdata;
    if (rst) edgeCnt <= 0; else edgeCnt <= edgeCnt + 1;
  end

  always @(negedge clk) begin
    if (rst) begin
      nOut = 0; writeCount = 0; firstStrobeEdge = -1;
    end else begin
      if (outStrobe) begin
        if (nOut == 0) firstStrobeEdge = edgeCnt;
        if (nOut < 16) outLog[nOut] = outPort;
        nOut++;
      end
      if (memWe) writeCount++;
    end
  end

  function automatic logic [15:0] ins(input int op, input int addr);
    return {op[3:0], addr[11:0]};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clearMem();
    for (int i = 0; i < 256; i++) mem[i] = 16'h0000;
  endtask

  task automatic enterReset();
    @(negedge clk); rst = 1'b1; irqReq = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic runUntilHalt(input string req, input int limit);
    int n = 0;
    @(negedge clk); rst = 1'b0;
    while (!halted && n < limit) begin @(negedge clk); n++; end
    chk({req, " halt reached"}, halted, 1'b1);
    repeat (3) @(negedge clk);
  endtask

  task automatic testReset();
    enterReset(); clearMem();
    mem[0] = ins(9, 0);
    chk("R1 halted in reset", halted, 1'b0);
    chk("R1 memWe in reset", memWe, 1'b0);
    chk("R1 strobe in reset", outStrobe, 1'b0);
    @(negedge clk); rst = 1'b0;
    chk("R1 halted after release", halted, 1'b0);
    chk("R1 memWe after release", memWe, 1'b0);
    chk("R1 fetch address", memAddr, 12'd0);
  endtask

  task automatic testTiming();
    enterReset(); clearMem();
    mem[0] = ins(4, 20); mem[1] = ins(8, 0); mem[2] = ins(9, 0);
    mem[20] = 16'h1234;
    runUntilHalt("R2", 100);
    chk("R2 first strobe edge", firstStrobeEdge, 10);
    chk("R3 load value", outLog[0], 16'h1234);
  endtask

  task automatic testArith();
    enterReset(); clearMem();
    mem[0] = ins(4, 20); mem[1] = ins(0, 21); mem[2] = ins(8, 0);
    mem[3] = ins(1, 22); mem[4] = ins(8, 0); mem[5] = ins(9, 0);
    mem[20] = 16'hFFF0; mem[21] = 16'h0025; mem[22] = 16'h00F3;
    runUntilHalt("R3", 200);
    chk("R3 out count", nOut, 2);
    chk("R3 add wraps", outLog[0], 16'h0015);
    chk("R3 and", outLog[1], 16'h0011);
  endtask

  task automatic testRotClr();
    enterReset(); clearMem();
    mem[0] = ins(4, 20); mem[1] = ins(3, 0); mem[2] = ins(8, 0);
    mem[3] = ins(3, 0); mem[4] = ins(8, 0); mem[5] = ins(2, 0);
    mem[6] = ins(8, 0); mem[7] = ins(9, 0);
    mem[20] = 16'h8001;
    runUntilHalt("R4", 200);
    chk("R4 rotate msb wraps", outLog[0], 16'h0003);
    chk("R4 rotate again", outLog[1], 16'h0006);
    chk("R4 clear", outLog[2], 16'h0000);
  endtask

  task automatic testStore();
    enterReset(); clearMem();
    mem[0] = ins(4, 20); mem[1] = ins(5, 30); mem[2] = ins(9, 0);
    mem[20] = 16'hBEEF; mem[31] = 16'h7777;
    runUntilHalt("R5", 100);
    chk("R5 stored word", mem[30], 16'hBEEF);
    chk("R5 neighbour untouched", mem[31], 16'h7777);
    chk("R5 one write cycle", writeCount, 1);
  endtask

  task automatic testJump();
    enterReset(); clearMem();
    mem[0] = ins(2, 0); mem[1] = ins(6, 4); mem[2] = ins(8, 0); mem[3] = ins(9, 0);
    mem[4] = ins(4, 20); mem[5] = ins(6, 8); mem[6] = ins(8, 0); mem[7] = ins(9, 0);
    mem[8] = ins(8, 0); mem[9] = ins(9, 0);
    mem[20] = 16'h0005;
    runUntilHalt("R6", 200);
    chk("R6 taken and not-taken path count", nOut, 1);
    chk("R6 fall-through value", outLog[0], 16'h0005);
  endtask

  task automatic testInNop();
    enterReset(); clearMem();
    inPort = 16'h5A5A;
    mem[0] = ins(7, 0); mem[1] = ins(8, 0); mem[2] = ins(4, 20);
    for (int k = 0; k < 5; k++) mem[3 + k] = ins(11 + k, 30);
    mem[8] = ins(8, 0); mem[9] = ins(9, 0);
    mem[20] = 16'h0077; mem[30] = 16'h1111;
    runUntilHalt("R9", 200);
    chk("R7 input to output", outLog[0], 16'h5A5A);
    chk("R9 acc kept over 11..15", outLog[1], 16'h0077);
    chk("R9 no memory write", writeCount, 0);
    chk("R9 word 30 unchanged", mem[30], 16'h1111);
  endtask

  task automatic testHalt();
    enterReset(); clearMem();
    mem[0] = ins(9, 0); mem[1] = ins(8, 0); mem[2] = ins(5, 10);
    runUntilHalt("R8", 50);
    repeat (40) @(negedge clk);
    chk("R8 still halted", halted, 1'b1);
    chk("R8 no strobe", nOut, 0);
    chk("R8 no write", writeCount, 0);
  endtask

  task automatic testIrq();
    enterReset(); clearMem();
    inPort = 16'h0C0C;
    mem[0] = ins(6, 8);
    mem[1] = ins(7, 0); mem[2] = ins(8, 0); mem[3] = ins(4, 40); mem[4] = ins(10, 0);
    mem[8] = ins(4, 40); mem[9] = ins(8, 0); mem[10] = ins(8, 0); mem[11] = ins(9, 0);
    mem[40] = 16'h0011;
    fork
      runUntilHalt("R10", 400);
      begin
        wait (edgeCnt == 5); @(negedge clk); irqReq = 1'b1; @(negedge clk); irqReq = 1'b0;
        wait (edgeCnt == 13); @(negedge clk); irqReq = 1'b1; @(negedge clk); irqReq = 1'b0;
      end
    join
    chk("R10 saved return address", mem[0], 16'd9);
    chk("R11 output count", nOut, 4);
    chk("R12 pulse taken, routine output", outLog[0], 16'h0C0C);
    chk("R11 re-entry after return", outLog[1], 16'h0C0C);
    chk("R11 resumed main first", outLog[2], 16'h0011);
    chk("R10 resumed main second", outLog[3], 16'h0011);
  endtask

  initial begin
    irqReq = 1'b0; inPort = 16'h0;
    testReset();
    testTiming();
    testArith();
    testRotClr();
    testStore();
    testJump();
    testInNop();
    testHalt();
    testIrq();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule